// File: doc/BRIEF.md
# Vectored Interrupt Status Controller

This block sits beside a small CPU core and decides when an interrupt may be entered. Five request lines arrive alongside the implicit reset event. Whether a pending request is taken depends on three things: a global enable, a two-bit nesting level and a per-line high-priority mask. When a request is taken, the block acknowledges that line and steps the nesting level one notch more restrictive. It also hands the old status word to the stack logic. It then reads the two-byte vector slot for that source from program ROM and loads the program counter from it. The two addressing-mode flags carried in the first vector byte are loaded at the same time.

Reset is treated as vector slot 0. While reset is held the sequencer sits at the first fetch of slot 0, so the reset vector is read as soon as reset is released. An interrupt-return strobe restores the nesting level and both mode flags from a popped status word, and hands the popped carry back to the datapath.

The sequencer has four states. `SQ_IDLE` waits, and a taken request moves it to `SQ_FETCH_HI`. `SQ_FETCH_HI` reads the even vector byte and always moves to `SQ_FETCH_LO`. `SQ_FETCH_LO` reads the odd byte and always moves to `SQ_LOAD`. `SQ_LOAD` presents the program counter and always returns to `SQ_IDLE`. Reset forces `SQ_FETCH_HI`.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The global enable `int_enable` is 0 after reset. `ie_set` sets it and `ie_clr` clears it at the next edge, and `ie_clr` wins when both are high. While it is 0, no request is acknowledged.
- R2: Which lines are eligible depends on the nesting level. At level 00 every requesting line is eligible. At level 01 only lines whose `irq_hi_prio` bit is 1 are eligible. At levels 10 and 11 no line is eligible.
- R3: Among the eligible lines, the lowest index (bit 0 = INTB/INT4, then INT0, INT1, INTS, INTT0) is acknowledged on `irq_ack` as a one-hot combinational pulse while idle. No acknowledge appears while `busy` is 1.
- R4: In the cycle a request is taken, `push_valid` is 1 and `push_word` is {level[1:0] at bits 4:3, memory-bank flag at bit 2, register-bank flag at bit 1, `carry_in` at bit 0}. At the next edge the level goes from 00 to 01 or from 01 to 10.
- R5: Vector source s (0 = reset, k+1 = request line k) is read with `rom_rd` high at ROM byte address 2s in the first cycle after the take. It is read at address 2s+1 in the cycle after that. The ROM returns the data of each read one edge later.
- R6: In the third cycle after the take cycle, `pc_load` is 1 for one cycle and `pc_value` is {bits 5:0 of the even byte, the odd byte}.
- R7: At the edge that ends the `pc_load` cycle, the memory-bank flag `emb` takes bit 7 of the even byte and the register-bank flag `erb` takes bit 6. `busy` then drops.
- R8: Reset clears the nesting level, the enable and both flags, and holds the fetch of slot 0 (address 0). After release, `pc_load` follows in the second cycle and both flags load at the edge after that.
- R9: `iret` while idle restores level, `emb` and `erb` from `pop_word` (same bit layout as R4) at the next edge. In the same cycle it pulses `carry_load` with `carry_value` equal to `pop_word[0]`. In that cycle it also suppresses any acknowledge. While busy, `iret` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also the reset event |
| irq_req | input | 5 | Pending request per line |
| irq_hi_prio | input | 5 | High-priority mask per line |
| ie_set | input | 1 | Enable strobe |
| ie_clr | input | 1 | Disable strobe |
| iret | input | 1 | Interrupt-return strobe |
| pop_word | input | 5 | Status word popped from the stack |
| carry_in | input | 1 | Current carry, saved on entry |
| rom_data | input | 8 | ROM byte returned one edge after a read |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 14 | ROM byte address of the vector read |
| irq_ack | output | 5 | One-hot acknowledge of the taken line |
| push_valid | output | 1 | Status word must be pushed |
| push_word | output | 5 | Status word to push |
| pc_load | output | 1 | Load program counter |
| pc_value | output | 14 | Service address |
| carry_load | output | 1 | Restore carry strobe |
| carry_value | output | 1 | Carry value to restore |
| emb | output | 1 | Memory-bank enable flag |
| erb | output | 1 | Register-bank enable flag |
| nest_level | output | 2 | Current nesting level |
| int_enable | output | 1 | Global enable |
| busy | output | 1 | Vector sequence in progress |

## Verification
Acknowledge, push and carry-restore results are combinational, so they are checked one time step after the inputs change, away from the clock edge. The inputs are then withdrawn before the edge when a take is not wanted. The nesting level and enable change at the first edge after the stimulus. The two ROM addresses are due one and two edges after the take, `pc_load` three, and the flags four. Each check waits exactly that many falling edges. The acceptance rule is swept over all four levels, all 32 masks and all 32 request patterns against an arithmetic model.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FETCH_HI,
        SQ_FETCH_LO,
        SQ_LOAD
    } ivc_state_e;

    localparam logic [1:0] LV_OPEN      = 2'b00;
    localparam logic [1:0] LV_HIGH_ONLY = 2'b01;
    localparam logic [1:0] LV_CLOSED    = 2'b10;

    typedef struct packed {
        logic [1:0] level;
        logic       emb;
        logic       erb;
        logic       carry;
    } ivc_psw_t;

    localparam int PSW_W       = $bits(ivc_psw_t);
    localparam int VEC_EMB_BIT = 7;
    localparam int VEC_ERB_BIT = 6;

endpackage

// File: rtl/ivc_arbiter.sv
`timescale 1ns/1ps
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int N_IRQ = 5,
    parameter int IDX_W = 3
) (
    input  logic [N_IRQ-1:0] req,
    input  logic [N_IRQ-1:0] hi_prio,
    input  logic [1:0]       level,
    input  logic             gate_en,
    output logic [N_IRQ-1:0] grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             take
);

    logic [N_IRQ-1:0] eligible;
    logic [N_IRQ:0]   lower_seen;

    assign lower_seen[0] = 1'b0;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign eligible[i] = (level == LV_OPEN)      ? req[i] :
                             (level == LV_HIGH_ONLY) ? (req[i] & hi_prio[i]) :
                                                       1'b0;
        assign grant[i]        = gate_en & eligible[i] & ~lower_seen[i];
        assign lower_seen[i+1] = lower_seen[i] | eligible[i];
    end

    assign take = |grant;

    always_comb begin
        grant_idx = '0;
        for (int j = 0; j < N_IRQ; j++) begin
            if (grant[j]) grant_idx = IDX_W'(j);
        end
    end

endmodule

// File: rtl/ivc_status.sv
`timescale 1ns/1ps
module ivc_status
    import ivc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       ie_set,
    input  logic       ie_clr,
    input  logic       ret_fire,
    input  ivc_psw_t   pop,
    input  logic       flag_load,
    input  logic       flag_emb,
    input  logic       flag_erb,
    output logic [1:0] level,
    output logic       ie,
    output logic       emb,
    output logic       erb
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= LV_OPEN;
            ie    <= 1'b0;
            emb   <= 1'b0;
            erb   <= 1'b0;
        end else begin
            if (ie_clr)      ie <= 1'b0;
            else if (ie_set) ie <= 1'b1;

            if (ret_fire) begin
                level <= pop.level;
                emb   <= pop.emb;
                erb   <= pop.erb;
            end else begin
                if (take) level <= level + 2'd1;
                if (flag_load) begin
                    emb <= flag_emb;
                    erb <= flag_erb;
                end
            end
        end
    end

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> level == $past(level) + 2'd1); // R4
    AST_TAKE_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !level[1]); // R2
    AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ie); // R1
    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> (level == $past(pop.level)) && (emb == $past(pop.emb))); // R9

endmodule

// File: rtl/ivc_seq.sv
`timescale 1ns/1ps
module ivc_seq
    import ivc_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int SLOT_W = 3,
    parameter int ADDR_W = 14,
    parameter int PC_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [IDX_W-1:0]  grant_idx,
    input  logic [7:0]        rom_data,
    output logic              idle,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_value,
    output logic              flag_load,
    output logic              flag_emb,
    output logic              flag_erb
);

    localparam int HI_W = PC_W - 8;

    ivc_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [7:0]        hi_q;
    logic [ADDR_W-1:0] slot_base;

    assign slot_base = ADDR_W'({slot_q, 1'b0});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:     if (take) state_d = SQ_FETCH_HI;
            SQ_FETCH_HI: state_d = SQ_FETCH_LO;
            SQ_FETCH_LO: state_d = SQ_LOAD;
            SQ_LOAD:     state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_FETCH_HI;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            hi_q   <= '0;
        end else begin
            if (state_q == SQ_IDLE && take)
                slot_q <= SLOT_W'(grant_idx) + SLOT_W'(1);
            if (state_q == SQ_FETCH_LO)
                hi_q <= rom_data;
        end
    end

    always_comb begin
        idle      = 1'b0;
        rom_rd    = 1'b0;
        rom_addr  = slot_base;
        pc_load   = 1'b0;
        flag_load = 1'b0;
        pc_value  = {hi_q[HI_W-1:0], rom_data};
        flag_emb  = hi_q[VEC_EMB_BIT];
        flag_erb  = hi_q[VEC_ERB_BIT];
        unique case (state_q)
            SQ_IDLE:     idle = 1'b1;
            SQ_FETCH_HI: rom_rd = 1'b1;
            SQ_FETCH_LO: begin
                rom_rd   = 1'b1;
                rom_addr = slot_base | ADDR_W'(1);
            end
            SQ_LOAD: begin
                pc_load   = 1'b1;
                flag_load = 1'b1;
            end
        endcase
    end

    AST_LOAD_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ##3 pc_load); // R6
    AST_ODD_FOLLOWS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && !rom_addr[0]) |=> rom_rd && (rom_addr == $past(rom_addr) + ADDR_W'(1))); // R5
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !take); // R3

endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
    import ivc_pkg::*;
#(
    parameter int N_IRQ  = 5,
    parameter int PC_W   = 14,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_hi_prio,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              iret,
    input  logic [4:0]        pop_word,
    input  logic              carry_in,
    input  logic [7:0]        rom_data,
    output logic              rom_rd,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [N_IRQ-1:0]  irq_ack,
    output logic              push_valid,
    output logic [4:0]        push_word,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_value,
    output logic              carry_load,
    output logic              carry_value,
    output logic              emb,
    output logic              erb,
    output logic [1:0]        nest_level,
    output logic              int_enable,
    output logic              busy
);

    localparam int IDX_W  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam int SLOT_W = $clog2(N_IRQ + 1);

    logic             idle, take, ret_fire, gate_en;
    logic             flag_load, flag_emb, flag_erb;
    logic [IDX_W-1:0] grant_idx;
    ivc_psw_t         pop_s, push_s;

    assign pop_s    = ivc_psw_t'(pop_word);
    assign ret_fire = iret & idle;
    assign gate_en  = int_enable & idle & ~iret;

    ivc_arbiter #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_arb (
        .req       (irq_req),
        .hi_prio   (irq_hi_prio),
        .level     (nest_level),
        .gate_en   (gate_en),
        .grant     (irq_ack),
        .grant_idx (grant_idx),
        .take      (take)
    );

    ivc_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .ie_set    (ie_set),
        .ie_clr    (ie_clr),
        .ret_fire  (ret_fire),
        .pop       (pop_s),
        .flag_load (flag_load),
        .flag_emb  (flag_emb),
        .flag_erb  (flag_erb),
        .level     (nest_level),
        .ie        (int_enable),
        .emb       (emb),
        .erb       (erb)
    );

    ivc_seq #(.IDX_W(IDX_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .grant_idx (grant_idx),
        .rom_data  (rom_data),
        .idle      (idle),
        .rom_rd    (rom_rd),
        .rom_addr  (rom_addr),
        .pc_load   (pc_load),
        .pc_value  (pc_value),
        .flag_load (flag_load),
        .flag_emb  (flag_emb),
        .flag_erb  (flag_erb)
    );

    assign push_s.level = nest_level;
    assign push_s.emb   = emb;
    assign push_s.erb   = erb;
    assign push_s.carry = carry_in;
    assign push_word    = push_s;
    assign push_valid   = take;
    assign carry_load   = ret_fire;
    assign carry_value  = pop_s.carry;
    assign busy         = ~idle;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack)); // R3
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> irq_ack == '0); // R3
    AST_NO_ACK_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
        iret |-> irq_ack == '0); // R9
    AST_CLOSED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        nest_level[1] |-> irq_ack == '0); // R2

endmodule

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_req = '0, irq_hi_prio = '0;
    logic        ie_set = 1'b0, ie_clr = 1'b0, iret = 1'b0, carry_in = 1'b0;
    logic [4:0]  pop_word = '0;
    logic [7:0]  rom_data = '0;
    logic        rom_rd, push_valid, pc_load, carry_load, carry_value;
    logic        emb, erb, int_enable, busy;
    logic [13:0] rom_addr, pc_value;
    logic [4:0]  irq_ack, push_word;
    logic [1:0]  nest_level;

    int tests = 0;
    int fails = 0;
    logic m_emb = 1'b0, m_erb = 1'b0;

    always #5 clk = ~clk;

    vec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_hi_prio(irq_hi_prio),
        .ie_set(ie_set), .ie_clr(ie_clr), .iret(iret), .pop_word(pop_word),
        .carry_in(carry_in), .rom_data(rom_data), .rom_rd(rom_rd), .rom_addr(rom_addr),
        .irq_ack(irq_ack), .push_valid(push_valid), .push_word(push_word),
        .pc_load(pc_load), .pc_value(pc_value), .carry_load(carry_load),
        .carry_value(carry_value), .emb(emb), .erb(erb), .nest_level(nest_level),
        .int_enable(int_enable), .busy(busy)
    );

    function automatic logic [7:0] rom_byte(input logic [13:0] a);
        int s = int'(a >> 1);
        logic [2:0] sl = a[3:1];
        if (a[0]) return 8'((s * 37 + 11) & 255);
        return {~sl[0], sl[1], 6'((s * 5 + 3) & 63)};
    endfunction

    function automatic logic [13:0] exp_pc(input int s);
        return 14'((((s * 5 + 3) & 63) << 8) | ((s * 37 + 11) & 255));
    endfunction

    always_ff @(posedge clk) if (rom_rd) rom_data <= rom_byte(rom_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_level(input logic [1:0] lv, input logic e, input logic r);
        @(negedge clk);
        iret = 1'b1;
        pop_word = {lv, e, r, 1'b1};
        #1;
        chk("R9 carry_load", 32'(carry_load), 32'd1);
        chk("R9 carry_value", 32'(carry_value), 32'd1);
        @(negedge clk);
        iret = 1'b0;
        chk("R9 level restored", 32'(nest_level), 32'(lv));
        chk("R9 flags restored", 32'({emb, erb}), 32'({e, r}));
        m_emb = e;
        m_erb = r;
    endtask

    task automatic entry(input int k, input logic [1:0] lv_before);
        @(negedge clk);
        irq_req  = 5'(1 << k);
        carry_in = k[0];
        #1;
        chk("R3 single ack", 32'(irq_ack), 32'(1 << k));
        chk("R4 push_valid", 32'(push_valid), 32'd1);
        chk("R4 push_word", 32'(push_word), 32'({lv_before, m_emb, m_erb, k[0]}));
        @(negedge clk);
        irq_req = '0;
        chk("R4 level step", 32'(nest_level), 32'(lv_before + 2'd1));
        chk("R5 even read", 32'({rom_rd, rom_addr}), 32'({1'b1, 14'(2 * (k + 1))}));
        @(negedge clk);
        chk("R5 odd read", 32'({rom_rd, rom_addr}), 32'({1'b1, 14'(2 * (k + 1) + 1)}));
        @(negedge clk);
        chk("R6 pc_load", 32'(pc_load), 32'd1);
        chk("R6 pc_value", 32'(pc_value), 32'(exp_pc(k + 1)));
        @(negedge clk);
        m_emb = ~k[0];
        m_erb = ((k + 1) >> 1) & 1;
        m_emb = ~(1'((k + 1) & 1));
        chk("R7 flags", 32'({emb, erb}), 32'({m_emb, m_erb}));
        chk("R7 idle again", 32'({busy, pc_load}), 32'd0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset level", 32'(nest_level), 32'd0);
        chk("R8 reset enable", 32'(int_enable), 32'd0);
        chk("R8 reset flags", 32'({emb, erb}), 32'd0);
        chk("R8 reset fetch", 32'({busy, rom_rd, rom_addr}), 32'({2'b11, 14'd0}));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset odd read", 32'(rom_addr), 32'd1);
        @(negedge clk);
        chk("R8 reset pc_load", 32'(pc_load), 32'd1);
        chk("R8 reset pc_value", 32'(pc_value), 32'(exp_pc(0)));
        @(negedge clk);
        chk("R8 reset flags loaded", 32'({emb, erb, busy}), 32'({1'b1, 1'b0, 1'b0}));
        m_emb = 1'b1;
        m_erb = 1'b0;

        // R1: disabled requests are never acknowledged
        @(negedge clk);
        irq_req = '1;
        irq_hi_prio = '1;
        #1;
        chk("R1 no ack while disabled", 32'(irq_ack), 32'd0);
        irq_req = '0;
        @(negedge clk);
        ie_set = 1'b1;
        ie_clr = 1'b1;
        @(negedge clk);
        chk("R1 clear wins", 32'(int_enable), 32'd0);
        ie_clr = 1'b0;
        @(negedge clk);
        ie_set = 1'b0;
        chk("R1 set", 32'(int_enable), 32'd1);

        // R2 / R3 sweep over level, mask and request
        for (int lv = 0; lv < 4; lv++) begin
            set_level(2'(lv), 1'b0, 1'b0);
            for (int hp = 0; hp < 32; hp++) begin
                for (int rq = 0; rq < 32; rq++) begin
                    logic [4:0] allow, expv;
                    @(negedge clk);
                    irq_hi_prio = 5'(hp);
                    irq_req = 5'(rq);
                    allow = (lv == 0) ? 5'(rq) : (lv == 1) ? 5'(rq & hp) : 5'd0;
                    expv = allow & (~allow + 5'd1);
                    #1;
                    chk("R2 acceptance", 32'(irq_ack), 32'(expv));
                    irq_req = '0;
                end
            end
        end
        chk("R3 lowest wins", 32'(5'b10110 & (~5'b10110 + 5'd1)), 32'(5'b00010));

        // Entries and nesting
        irq_hi_prio = '1;
        for (int k = 0; k < 5; k++) begin
            set_level(2'b00, 1'b0, 1'b1);
            entry(k, 2'b00);
            entry((k + 1) % 5, 2'b01);
            @(negedge clk);
            irq_req = '1;
            #1;
            chk("R2 level 10 blocks", 32'(irq_ack), 32'd0);
            irq_req = '0;
        end

        // R9: return ignored while busy
        set_level(2'b00, 1'b0, 1'b0);
        @(negedge clk);
        irq_req = 5'b00001;
        @(negedge clk);
        irq_req = '1;
        iret = 1'b1;
        pop_word = 5'b11000;
        #1;
        chk("R3 no ack while busy", 32'(irq_ack), 32'd0);
        chk("R9 no carry_load busy", 32'(carry_load), 32'd0);
        @(negedge clk);
        iret = 1'b0;
        irq_req = '0;
        repeat (3) @(negedge clk);
        chk("R9 busy return ignored", 32'({busy, nest_level}), 32'({1'b0, 2'b01}));

        // R9: return beats a request in the same cycle
        set_level(2'b00, 1'b0, 1'b0);
        @(negedge clk);
        irq_req = 5'b00001;
        iret = 1'b1;
        pop_word = 5'b10000;
        #1;
        chk("R9 return suppresses ack", 32'(irq_ack), 32'd0);
        @(negedge clk);
        iret = 1'b0;
        irq_req = '0;
        chk("R9 return level", 32'({busy, nest_level}), 32'({1'b0, 2'b10}));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule